// File: doc/BRIEF.md
# Secure Exception Entry Sequencer

This block replaces the ordinary exception entry path of a small CPU core. When an exception request arrives, it captures the interrupted instruction pointer and the error code. It asks the protection unit which code region holds that pointer, and from the answer decides whether a protected software module was running. If one was, the sequencer spills the module's general-purpose registers onto the module's own stack. It then records the resulting stack pointer in that module's row of a per-region table in memory and zeroes every general-purpose register. Only after these steps does an untrusted handler get control.

After the optional protected-state steps, the sequencer chooses the stack for the exception frame. It uses the OS stack pointer unless the interrupted code was already running in the OS region, so a handler that is itself interrupted keeps stacking on its own stack. It pushes the reported instruction pointer and the error code, writes the final stack pointer back into the register file, and redirects the program counter to the handler vector. For a protected module the reported instruction pointer is replaced by that module's entry vector, which hides where it was interrupted. Resuming is a plain jump to the module's entry point and needs no help from this block.

The register file is reached through one combinational read port and one write port. Memory is reached through a single write port. A request is a level that stays pending until the sequencer is idle.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, with no request pending, `exc_ack`, `mem_we`, `rf_we`, `pc_we` and `done` are all 0.
- R2: An exception is treated as protected exactly when `mpu_hit` is 1 and `mpu_idx` differs from the OS region index `OS_IDX`; a miss or the OS index takes the plain path.
- R3: On the protected path, the NREG-1 registers other than the stack pointer (register `SP_IDX`) are written to memory one per cycle, in ascending register number, at addresses SP-WB, SP-2·WB, … (WB = XLEN/8), where SP is the stack-pointer value at the time of the exception.
- R4: On the protected path, the next memory write stores SP-(NREG-1)·WB at address TBL_BASE + region·TBL_STRIDE.
- R5: On the protected path, all NREG registers are then cleared, so at handler entry every register other than the stack pointer reads 0.
- R6: The exception frame is built below `os_sp` unless the interrupted pointer lies in region `OS_IDX`, in which case it is built below the current stack pointer.
- R7: The frame is two memory writes: the reported pointer at frame base minus WB, then the error code at frame base minus 2·WB. At handler entry the stack-pointer register holds frame base minus 2·WB.
- R8: For a protected exception the reported pointer is `mpu_entry` (when `HIDE_IP` is 1); otherwise it is the interrupted pointer unchanged.
- R9: Handler entry is a single-cycle `done` pulse, together with `pc_we` and `pc_next` = `hnd_vec`.
- R10: Counting from the cycle of `exc_ack`, `done` comes 2·NREG+6 cycles later on the protected path and 6 cycles later on the plain path.
- R11: `exc_ack` is raised only while the sequencer is idle. A request held during a sequence is accepted in the first idle cycle, with the pointer present at that time.
- R12: On the plain path, the only memory writes are the two frame words, and every register other than the stack pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Exception request, level, held until acknowledged |
| exc_ip | input | XLEN | Interrupted instruction pointer |
| exc_code | input | XLEN | Error code to push |
| exc_ack | output | 1 | Request accepted this cycle |
| lu_ip | output | XLEN | Captured pointer sent to the protection unit |
| mpu_hit | input | 1 | `lu_ip` lies in a configured code region |
| mpu_idx | input | $clog2(NREGION) | Index of that region |
| mpu_entry | input | XLEN | Entry vector of that region |
| os_sp | input | XLEN | OS stack pointer |
| hnd_vec | input | XLEN | Handler address |
| rf_raddr | output | $clog2(NREG) | Register read address |
| rf_rdata | input | XLEN | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | $clog2(NREG) | Register write address |
| rf_wdata | output | XLEN | Register write data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | XLEN | Memory byte address |
| mem_wdata | output | XLEN | Memory write data |
| pc_we | output | 1 | Program counter load |
| pc_next | output | XLEN | New program counter |
| done | output | 1 | Handler entry pulse |

## Verification
The bench builds the block with NREG=6 and SP_IDX=2. With these values the stack pointer sits in the middle of the register numbering, so the spill order has to skip it, and a protected entry takes 18 cycles. OS_IDX=3 of four regions and HIDE_IP=1 let one run exercise a protected region, the OS region (a nested entry), and an unmapped pointer, and check that the entry vector replaces the pointer only in the first case. The table stride of 16 with region 1 makes a wrong row offset visible.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CLASSIFY, S_SPILL, S_SAVE_SP,
    S_SCRUB, S_SWITCH_SP, S_PUSH_FRAME, S_VECTOR
  } seq_state_t;

  // k-th spilled register: ascending order, stack pointer skipped
  function automatic int unsigned spill_reg(int unsigned k, int unsigned sp_idx);
    return (k < sp_idx) ? k : k + 1;
  endfunction

endpackage

// File: rtl/exc_step_ctr.sv
module exc_step_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/exc_classify.sv
module exc_classify #(
  parameter int XLEN    = 32,
  parameter int NREGION = 4,
  parameter int OS_IDX  = 3,
  parameter bit HIDE_IP = 1'b1,
  localparam int MIDX_W = $clog2(NREGION)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              lat,
  input  logic [XLEN-1:0]   exc_ip,
  input  logic [XLEN-1:0]   exc_code,
  input  logic              mpu_hit,
  input  logic [MIDX_W-1:0] mpu_idx,
  input  logic [XLEN-1:0]   mpu_entry,
  output logic              prot_now,
  output logic              prot_q,
  output logic              in_os_q,
  output logic [MIDX_W-1:0] idx_q,
  output logic [XLEN-1:0]   ip_q,
  output logic [XLEN-1:0]   code_q,
  output logic [XLEN-1:0]   rep_ip
);
  logic os_now;
  assign os_now   = mpu_hit && (mpu_idx == MIDX_W'(OS_IDX));
  assign prot_now = mpu_hit && !os_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= '0; code_q <= '0;
      prot_q <= 1'b0; in_os_q <= 1'b0; idx_q <= '0;
    end else begin
      if (cap) begin
        ip_q   <= exc_ip;
        code_q <= exc_code;
      end
      if (lat) begin
        prot_q  <= prot_now;
        in_os_q <= os_now;
        idx_q   <= mpu_idx;
      end
    end
  end

  generate
    if (HIDE_IP) begin : g_hide
      logic [XLEN-1:0] entry_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   entry_q <= '0;
        else if (lat) entry_q <= mpu_entry;
      end
      assign rep_ip = prot_q ? entry_q : ip_q;
    end else begin : g_show
      assign rep_ip = ip_q;
    end
  endgenerate

  // R2: a protected verdict never coexists with the OS region
  p_prot_not_os_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lat) |-> !(prot_q && in_os_q));
endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 8,
  parameter int SP_IDX     = 1,
  parameter int NREGION    = 4,
  parameter int unsigned TBL_BASE   = 32'h400,
  parameter int unsigned TBL_STRIDE = 16,
  localparam int RIDX_W = $clog2(NREG),
  localparam int MIDX_W = $clog2(NREGION),
  localparam int CNT_W  = $clog2(NREG + 1),
  localparam int WB     = XLEN / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CNT_W-1:0]  cnt,
  output logic              ctr_clr,
  input  logic              prot_now,
  input  logic              in_os_q,
  input  logic [MIDX_W-1:0] idx_q,
  input  logic [XLEN-1:0]   code_q,
  input  logic [XLEN-1:0]   rep_ip,
  input  logic [XLEN-1:0]   os_sp,
  input  logic [XLEN-1:0]   hnd_vec,
  output logic              exc_ack,
  output logic              lat,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_next,
  output logic              done
);
  seq_state_t st, nxt;
  logic [XLEN-1:0] sp_q, fsp_q;

  function automatic logic [XLEN-1:0] below(logic [XLEN-1:0] base, int unsigned n);
    return base - XLEN'(n) * XLEN'(WB);
  endfunction

  function automatic logic [XLEN-1:0] row_addr(logic [MIDX_W-1:0] idx);
    return XLEN'(TBL_BASE) + XLEN'(idx) * XLEN'(TBL_STRIDE);
  endfunction

  // events brought out for the assertions
  logic spill_evt, scrub_evt, push_evt;
  assign spill_evt = (st == S_SPILL);
  assign scrub_evt = (st == S_SCRUB);
  assign push_evt  = (st == S_PUSH_FRAME);

  always_comb begin
    nxt = st; ctr_clr = 1'b0;
    exc_ack = 1'b0; lat = 1'b0;
    rf_raddr = RIDX_W'(SP_IDX);
    rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0;
    mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    pc_we = 1'b0; pc_next = '0; done = 1'b0;
    unique case (st)
      S_IDLE: begin
        ctr_clr = 1'b1;
        if (exc_req) begin
          exc_ack = 1'b1;
          nxt = S_CLASSIFY;
        end
      end
      S_CLASSIFY: begin
        if (cnt == CNT_W'(1)) begin
          lat = 1'b1; ctr_clr = 1'b1;
          nxt = prot_now ? S_SPILL : S_SWITCH_SP;
        end
      end
      S_SPILL: begin
        rf_raddr  = RIDX_W'(spill_reg(int'(cnt), SP_IDX));
        mem_we    = 1'b1;
        mem_addr  = below(sp_q, int'(cnt) + 1);
        mem_wdata = rf_rdata;
        if (cnt == CNT_W'(NREG - 2)) begin
          ctr_clr = 1'b1; nxt = S_SAVE_SP;
        end
      end
      S_SAVE_SP: begin
        mem_we    = 1'b1;
        mem_addr  = row_addr(idx_q);
        mem_wdata = below(sp_q, NREG - 1);
        ctr_clr   = 1'b1; nxt = S_SCRUB;
      end
      S_SCRUB: begin
        rf_we    = 1'b1;
        rf_waddr = RIDX_W'(cnt);
        rf_wdata = '0;
        if (cnt == CNT_W'(NREG - 1)) begin
          ctr_clr = 1'b1; nxt = S_SWITCH_SP;
        end
      end
      S_SWITCH_SP: begin
        ctr_clr = 1'b1; nxt = S_PUSH_FRAME;
      end
      S_PUSH_FRAME: begin
        mem_we = 1'b1;
        if (cnt == '0) begin
          mem_addr = below(fsp_q, 1); mem_wdata = rep_ip;
        end else begin
          mem_addr = below(fsp_q, 2); mem_wdata = code_q;
          ctr_clr  = 1'b1; nxt = S_VECTOR;
        end
      end
      S_VECTOR: begin
        rf_we    = 1'b1;
        rf_waddr = RIDX_W'(SP_IDX);
        rf_wdata = below(fsp_q, 2);
        pc_we = 1'b1; pc_next = hnd_vec; done = 1'b1;
        ctr_clr = 1'b1; nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sp_q <= '0; fsp_q <= '0;
    end else begin
      st <= nxt;
      if (lat) sp_q <= rf_rdata;
      if (st == S_SWITCH_SP) fsp_q <= in_os_q ? sp_q : os_sp;
    end
  end

  // R11: acceptance leaves idle at once, so no back-to-back acks
  p_ack_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ack |=> !exc_ack);
  // R9: handler entry is a single-cycle pulse right after the frame push
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(push_evt));
  // R3: spill addresses step down by one word from a frozen base
  p_spill_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_evt && $past(spill_evt)) |-> (mem_addr == $past(mem_addr) - XLEN'(WB)));
  p_spill_base_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_evt && $past(spill_evt)) |-> $stable(sp_q));
  // R5: scrubbing touches registers only, never memory
  p_scrub_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_evt |-> (!mem_we && rf_we));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN       = 32,
  parameter int NREG       = 8,
  parameter int SP_IDX     = 1,
  parameter int NREGION    = 4,
  parameter int OS_IDX     = 3,
  parameter int unsigned TBL_BASE   = 32'h400,
  parameter int unsigned TBL_STRIDE = 16,
  parameter bit HIDE_IP    = 1'b1,
  localparam int RIDX_W = $clog2(NREG),
  localparam int MIDX_W = $clog2(NREGION),
  localparam int CNT_W  = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [XLEN-1:0]   exc_ip,
  input  logic [XLEN-1:0]   exc_code,
  output logic              exc_ack,
  output logic [XLEN-1:0]   lu_ip,
  input  logic              mpu_hit,
  input  logic [MIDX_W-1:0] mpu_idx,
  input  logic [XLEN-1:0]   mpu_entry,
  input  logic [XLEN-1:0]   os_sp,
  input  logic [XLEN-1:0]   hnd_vec,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_next,
  output logic              done
);
  logic [CNT_W-1:0]  cnt;
  logic              ctr_clr, lat, prot_now, prot_q, in_os_q;
  logic [MIDX_W-1:0] idx_q;
  logic [XLEN-1:0]   ip_q, code_q, rep_ip;

  exc_step_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .cnt(cnt));

  exc_classify #(.XLEN(XLEN), .NREGION(NREGION), .OS_IDX(OS_IDX), .HIDE_IP(HIDE_IP)) u_cls (
    .clk(clk), .rst_n(rst_n), .cap(exc_ack), .lat(lat),
    .exc_ip(exc_ip), .exc_code(exc_code),
    .mpu_hit(mpu_hit), .mpu_idx(mpu_idx), .mpu_entry(mpu_entry),
    .prot_now(prot_now), .prot_q(prot_q), .in_os_q(in_os_q), .idx_q(idx_q),
    .ip_q(ip_q), .code_q(code_q), .rep_ip(rep_ip));

  exc_entry_fsm #(.XLEN(XLEN), .NREG(NREG), .SP_IDX(SP_IDX), .NREGION(NREGION),
                  .TBL_BASE(TBL_BASE), .TBL_STRIDE(TBL_STRIDE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cnt(cnt), .ctr_clr(ctr_clr),
    .prot_now(prot_now), .in_os_q(in_os_q), .idx_q(idx_q), .code_q(code_q),
    .rep_ip(rep_ip), .os_sp(os_sp), .hnd_vec(hnd_vec),
    .exc_ack(exc_ack), .lat(lat),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_we(pc_we), .pc_next(pc_next), .done(done));

  assign lu_ip = ip_q;

  // R12: a plain (unprotected) entry never clears registers
  p_plain_no_scrub_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_q && rf_we) |-> (rf_waddr == RIDX_W'(SP_IDX)));
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  localparam int XLEN = 32, NREG = 6, SP_IDX = 2, NREGION = 4, OS_IDX = 3;
  localparam int unsigned TBLB = 32'h400, STR = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic exc_req = 1'b0; logic [31:0] exc_ip = '0, exc_code = '0;
  logic exc_ack; logic [31:0] lu_ip;
  logic mpu_hit; logic [1:0] mpu_idx; logic [31:0] mpu_entry;
  logic [31:0] os_sp = 32'h8000, hnd_vec = 32'h0000_0100;
  logic [2:0] rf_raddr, rf_waddr; logic [31:0] rf_rdata, rf_wdata; logic rf_we;
  logic mem_we; logic [31:0] mem_addr, mem_wdata;
  logic pc_we, done; logic [31:0] pc_next;

  int nvec = 0, nbad = 0;
  logic finished = 1'b0;

  // bench register file and memory-write log
  logic [31:0] rf [NREG];
  logic tb_we = 1'b0; logic [2:0] tb_wa = '0; logic [31:0] tb_wd = '0;
  logic [31:0] log_a [32]; logic [31:0] log_d [32];
  int nlog = 0; logic log_clr = 1'b0;
  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) begin
    if (tb_we) rf[tb_wa] <= tb_wd;
    else if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (log_clr) nlog <= 0;
    else if (mem_we && nlog < 32) begin
      log_a[nlog] <= mem_addr; log_d[nlog] <= mem_wdata; nlog <= nlog + 1;
    end
  end

  // protection-unit model: region r spans ((r+1)<<12) .. +0xFFF
  always_comb begin
    mpu_hit = (lu_ip >> 12) >= 1 && (lu_ip >> 12) <= 4;
    mpu_idx = 2'((lu_ip >> 12) - 1);
    mpu_entry = (lu_ip & ~32'hFFF) | 32'h10;
  end

  exc_entry_seq #(.XLEN(XLEN), .NREG(NREG), .SP_IDX(SP_IDX), .NREGION(NREGION),
                  .OS_IDX(OS_IDX), .TBL_BASE(TBLB), .TBL_STRIDE(STR), .HIDE_IP(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_ip(exc_ip), .exc_code(exc_code),
    .exc_ack(exc_ack), .lu_ip(lu_ip), .mpu_hit(mpu_hit), .mpu_idx(mpu_idx),
    .mpu_entry(mpu_entry), .os_sp(os_sp), .hnd_vec(hnd_vec),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_we(pc_we), .pc_next(pc_next), .done(done));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int spilled(int k);
    return (k < SP_IDX) ? k : k + 1;
  endfunction

  task automatic preload(logic [31:0] sp);
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk); tb_we = 1'b1; tb_wa = 3'(i);
      tb_wd = (i == SP_IDX) ? sp : 32'hA0 + 32'(i);
    end
    @(negedge clk); tb_we = 1'b0; log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  // waits for done; returns cycles since the ack cycle and acks seen meanwhile
  task automatic wait_done(output int lat, output int acks);
    lat = 0; acks = 0;
    do begin
      @(negedge clk); #0.5; lat++;
      if (exc_ack) acks++;
      if (done) begin
        chk("R9 pc_we", 32'(pc_we), 1);
        chk("R9 pc_next", pc_next, hnd_vec);
      end
    end while (!done && lat < 100);
    @(negedge clk); #0.5;
    chk("R9 done one cycle", 32'(done), 0);
  endtask

  task automatic start(logic [31:0] ip, logic [31:0] code);
    @(negedge clk); exc_ip = ip; exc_code = code; exc_req = 1'b1; #0.5;
    chk("R11 ack when idle", 32'(exc_ack), 1);
  endtask

  task automatic t_reset();
    #0.5;
    chk("R1 ack", 32'(exc_ack), 0); chk("R1 mem_we", 32'(mem_we), 0);
    chk("R1 rf_we", 32'(rf_we), 0); chk("R1 pc_we", 32'(pc_we), 0);
    chk("R1 done", 32'(done), 0);
  endtask

  task automatic t_protected(logic [31:0] ip, logic [31:0] sp, logic [31:0] code);
    int lat, acks; logic [31:0] region;
    region = (ip >> 12) - 1;
    preload(sp);
    start(ip, code);
    @(negedge clk); exc_req = 1'b0; #0.5;
    lat = 0; acks = 0;
    begin int l2, a2; wait_done(l2, a2); lat = l2 + 1; end
    chk("R10 protected latency", 32'(lat), 2 * NREG + 6);
    chk("R2 protected write count", 32'(nlog), NREG + 2);
    for (int k = 0; k < NREG - 1; k++) begin
      chk("R3 spill addr", log_a[k], sp - 32'(4 * (k + 1)));
      chk("R3 spill data", log_d[k], 32'hA0 + 32'(spilled(k)));
    end
    chk("R4 table addr", log_a[NREG-1], TBLB + region * STR);
    chk("R4 table data", log_d[NREG-1], sp - 32'(4 * (NREG - 1)));
    chk("R6 frame on os stack", log_a[NREG], os_sp - 4);
    chk("R8 entry vector reported", log_d[NREG], (ip & ~32'hFFF) | 32'h10);
    chk("R7 code addr", log_a[NREG+1], os_sp - 8);
    chk("R7 code data", log_d[NREG+1], code);
    for (int i = 0; i < NREG; i++)
      if (i != SP_IDX) chk("R5 scrubbed", rf[i], 0);
    chk("R7 final sp", rf[SP_IDX], os_sp - 8);
  endtask

  task automatic t_plain(logic [31:0] ip, logic [31:0] sp, logic [31:0] code, bit in_os);
    int lat, acks; logic [31:0] base;
    base = in_os ? sp : os_sp;
    preload(sp);
    start(ip, code);
    @(negedge clk); exc_req = 1'b0; #0.5;
    begin int l2, a2; wait_done(l2, a2); lat = l2 + 1; end
    chk("R10 plain latency", 32'(lat), 6);
    chk("R12 plain write count", 32'(nlog), 2);
    chk("R6 frame base", log_a[0], base - 4);
    chk("R8 raw ip reported", log_d[0], ip);
    chk("R7 code addr", log_a[1], base - 8);
    chk("R7 code data", log_d[1], code);
    for (int i = 0; i < NREG; i++)
      if (i != SP_IDX) chk("R12 regs kept", rf[i], 32'hA0 + 32'(i));
    chk("R7 final sp", rf[SP_IDX], base - 8);
  endtask

  task automatic t_pending();
    int lat, acks;
    preload(32'h1F00);
    start(32'h1234, 32'h11);
    @(negedge clk); exc_ip = 32'h9000; exc_code = 32'h22; #0.5;
    chk("R11 no ack while busy", 32'(exc_ack), 0);
    begin int l2; wait_done(l2, acks); end
    chk("R11 no ack before done", 32'(acks), 0);
    chk("R11 pending accepted in idle", 32'(exc_ack), 1);
    log_clr = 1'b1;
    @(negedge clk); exc_req = 1'b0; log_clr = 1'b0; #0.5;
    begin int l3, a3; wait_done(l3, a3); lat = l3 + 1; end
    chk("R10 second entry latency", 32'(lat), 6);
    chk("R11 second ip pushed", log_d[0], 32'h9000);
    chk("R11 second code pushed", log_d[1], 32'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); t_reset();
    t_protected(32'h2344, 32'h2F00, 32'hDEAD_0001);   // region 1
    t_protected(32'h1ABC, 32'h1E80, 32'h0000_0042);   // region 0
    t_plain(32'h4100, 32'h7F00, 32'h0000_0007, 1'b1); // OS region, nested
    t_plain(32'h9000, 32'h5000, 32'h0000_0009, 1'b0); // unmapped
    t_pending();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule